// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescale and Two-Strobe Clear

This block guards a processor against runaway software. It counts ticks from one of three clock enables: a free-running dedicated oscillator tick, a 32 kHz real-time tick, or the instruction-rate tick. A fixed 256-count base stage is followed by a prescaler. A 3-bit selection field in an 8-bit option register sets the prescale from 1:1 to 1:128. If software does not restart the count in time, the block raises a one-cycle request. While the core runs, that request asks for a full chip reset. While the core is halted, it asks for a warm reset, which restores only the program counter and the stack pointer.

Software restarts the count in one of two ways, chosen by a static strap. In single mode one clear strobe is enough. In paired mode two different clear strobes must both arrive before the count restarts. The block also keeps the two status flags that let start-up code tell power-up, external reset, halt wake-up and watchdog expiry apart. One flag records a watchdog timeout. The other records that the core entered the power-down state.

Top module: `wdog_top`

## Requirements
- R1: After power-up reset (`rst`), the timeout flag and power-down flag are 0, `cfg_rdata` reads 0x07 and neither request is asserted.
- R2: Let N be `cfg_rdata[2:0]`. On a tick, when the low 8+N bits of the running tick count are all ones, the block times out and the count restarts at 0. From a restart this gives 256·2^N ticks to expiry.
- R3: `clk_src_sel` picks the tick as follows: 0 selects `tick_osc`, 1 selects `tick_rtc`, and 2 or 3 selects `tick_instr`. `tick_instr` is ignored while `in_halt` is 1.
- R4: A timeout produces a one-cycle pulse in the cycle after the expiring tick. The pulse is on `chip_rst_req` if `in_halt` was 0 at that tick, and on `warm_rst_req` if it was 1. The two requests are never high together.
- R5: With `dual_clr_opt`=0, a `clr_one` strobe restarts the count. `clr_a` and `clr_b` have no effect.
- R6: With `dual_clr_opt`=1, the count restarts only once both `clr_a` and `clr_b` have been seen since the last restart, in either order or in the same cycle. `clr_one` has no effect. A restart by timeout, halt or external reset discards any strobe already seen.
- R7: A `halt_exec` strobe restarts the count, sets the power-down flag and clears the timeout flag.
- R8: A completed clear clears both flags. A timeout sets the timeout flag and leaves the power-down flag unchanged.
- R9: `ext_rst` restarts the count, discards partial clears and reloads the option register with 0x07. It leaves both flags unchanged.
- R10: A `cfg_we` write stores all 8 bits of `cfg_wdata`, which read back from the next cycle. Bits 7:3 have no effect on timing.
- R11: With `wdt_en_opt`=0, the count stays at 0, no request is raised and clear strobes change nothing, including the flags. `halt_exec` still sets the power-down flag and clears the timeout flag.
- R12: Priority is `rst` first, then `ext_rst`, then `halt_exec`, then a completed clear, then a tick. A clear that lands on the expiring tick prevents the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| ext_rst | input | 1 | External reset pin event |
| wdt_en_opt | input | 1 | Static option: watchdog enabled |
| dual_clr_opt | input | 1 | Static option: paired clear mode |
| clk_src_sel | input | 2 | Static option: tick source |
| tick_osc | input | 1 | Dedicated oscillator tick enable |
| tick_rtc | input | 1 | Real-time oscillator tick enable |
| tick_instr | input | 1 | Instruction-rate tick enable |
| halt_exec | input | 1 | HALT instruction executed (strobe) |
| in_halt | input | 1 | Core is in the halted state |
| clr_one | input | 1 | Single clear instruction strobe |
| clr_a | input | 1 | First paired clear strobe |
| clr_b | input | 1 | Second paired clear strobe |
| cfg_we | input | 1 | Option register write enable |
| cfg_wdata | input | 8 | Option register write data |
| cfg_rdata | output | 8 | Option register contents |
| chip_rst_req | output | 1 | Full chip reset request pulse |
| warm_rst_req | output | 1 | Warm reset request pulse |
| to_flag | output | 1 | Timeout status flag |
| pdf_flag | output | 1 | Power-down status flag |

## Verification
The hardest case to reach is a clear that coincides exactly with the expiring tick. This needs a clear strobe placed 256 cycles after a restart, with the smallest prescale and a tick in every cycle, so the bench counts edges from a known restart before issuing it. A second hard case is the loss of a half-finished paired clear when a timeout intervenes. The bench reaches it by issuing one paired strobe, letting the count expire, and then issuing the other, which must not restart the count. The bench model follows every cycle, so it shows any difference in request timing, flags or register contents at the cycle where it appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    parameter int BASE_W = 8;
    parameter int SEL_W  = 3;
    parameter int CFG_W  = 8;

    localparam int PS_STAGES = (1 << SEL_W) - 1;
    localparam int CNT_W     = BASE_W + PS_STAGES;

    typedef enum logic [1:0] {
        SRC_OSC   = 2'd0,
        SRC_RTC   = 2'd1,
        SRC_INSTR = 2'd2,
        SRC_ALT   = 2'd3
    } tick_src_e;

    // Events presented to the status keeper in one cycle.
    typedef struct packed {
        logic hard;      // external reset
        logic halt;      // HALT instruction
        logic cleared;   // clear sequence completed
        logic expired;   // timeout this cycle
        logic in_halt;   // core halted
    } wdog_evt_t;

    function automatic logic [CFG_W-1:0] cfg_reset_value();
        return CFG_W'(PS_STAGES);
    endfunction

    function automatic logic [SEL_W-1:0] cfg_sel(input logic [CFG_W-1:0] cfg);
        return cfg[SEL_W-1:0];
    endfunction

endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
    import wdog_pkg::*;
(
    input  tick_src_e src,
    input  logic      tick_osc,
    input  logic      tick_rtc,
    input  logic      tick_instr,
    input  logic      in_halt,
    output logic      tick
);

    always_comb begin
        case (src)
            SRC_OSC: tick = tick_osc;
            SRC_RTC: tick = tick_rtc;
            default: tick = tick_instr & ~in_halt;  // instruction clock stops in halt
        endcase
    end

endmodule

// File: rtl/wdog_clr_seq.sv
module wdog_clr_seq (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic dual_mode,
    input  logic clr_one,
    input  logic clr_a,
    input  logic clr_b,
    input  logic flush,
    output logic done
);

    logic seen_a_q, seen_b_q;
    logic seen_a_d, seen_b_d;

    always_comb begin
        seen_a_d = seen_a_q | clr_a;
        seen_b_d = seen_b_q | clr_b;
        if (!enable)
            done = 1'b0;
        else if (dual_mode)
            done = seen_a_d & seen_b_d;
        else
            done = clr_one;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || !dual_mode || flush || done) begin
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
        end else begin
            seen_a_q <= seen_a_d;
            seen_b_q <= seen_b_d;
        end
    end

endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
    parameter int BASE_W = wdog_pkg::BASE_W,
    parameter int SEL_W  = wdog_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             timeout
);

    localparam int STAGES = (1 << SEL_W) - 1;
    localparam int CNT_W  = BASE_W + STAGES;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic             wrap;

    // Base stage is always part of the wrap test; prescale stages join per sel.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        if (i < BASE_W) begin : g_base
            assign mask[i] = 1'b1;
        end else begin : g_pre
            assign mask[i] = (SEL_W'(i - BASE_W) < sel);
        end
    end

    assign wrap    = &(cnt_q | ~mask);
    assign timeout = tick & ~restart & wrap;

    always_ff @(posedge clk) begin
        if (rst || restart || timeout)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
#(
    parameter int CFG_W_P = wdog_pkg::CFG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  wdog_evt_t          evt,
    input  logic               cfg_we,
    input  logic [CFG_W_P-1:0] cfg_wdata,
    output logic [CFG_W_P-1:0] cfg_q,
    output logic               to_flag,
    output logic               pdf_flag,
    output logic               chip_req,
    output logic               warm_req
);

    localparam logic [CFG_W_P-1:0] CFG_RST = CFG_W_P'(cfg_reset_value());

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CFG_RST;
            to_flag  <= 1'b0;
            pdf_flag <= 1'b0;
            chip_req <= 1'b0;
            warm_req <= 1'b0;
        end else begin
            chip_req <= evt.expired & ~evt.in_halt & ~evt.hard;
            warm_req <= evt.expired &  evt.in_halt & ~evt.hard;

            if (evt.hard)
                cfg_q <= CFG_RST;
            else if (cfg_we)
                cfg_q <= cfg_wdata;

            if (!evt.hard) begin
                if (evt.halt) begin
                    pdf_flag <= 1'b1;
                    to_flag  <= 1'b0;
                end else if (evt.cleared) begin
                    pdf_flag <= 1'b0;
                    to_flag  <= 1'b0;
                end else if (evt.expired) begin
                    to_flag  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_rst,
    input  logic       wdt_en_opt,
    input  logic       dual_clr_opt,
    input  logic [1:0] clk_src_sel,
    input  logic       tick_osc,
    input  logic       tick_rtc,
    input  logic       tick_instr,
    input  logic       halt_exec,
    input  logic       in_halt,
    input  logic       clr_one,
    input  logic       clr_a,
    input  logic       clr_b,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       chip_rst_req,
    output logic       warm_rst_req,
    output logic       to_flag,
    output logic       pdf_flag
);

    logic       tick;
    logic       clr_done;
    logic       restart;
    logic       expired;
    logic [7:0] cfg_q;
    wdog_evt_t  evt;

    wdog_tick_sel u_tick (
        .src        (tick_src_e'(clk_src_sel)),
        .tick_osc   (tick_osc),
        .tick_rtc   (tick_rtc),
        .tick_instr (tick_instr),
        .in_halt    (in_halt),
        .tick       (tick)
    );

    wdog_clr_seq u_clr (
        .clk       (clk),
        .rst       (rst),
        .enable    (wdt_en_opt),
        .dual_mode (dual_clr_opt),
        .clr_one   (clr_one),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .flush     (ext_rst | halt_exec | expired),
        .done      (clr_done)
    );

    assign restart = ~wdt_en_opt | ext_rst | halt_exec | clr_done;

    wdog_divider #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .sel     (cfg_sel(cfg_q)),
        .timeout (expired)
    );

    always_comb begin
        evt.hard    = ext_rst;
        evt.halt    = halt_exec;
        evt.cleared = clr_done;
        evt.expired = expired;
        evt.in_halt = in_halt;
    end

    wdog_status #(.CFG_W_P(8)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .to_flag   (to_flag),
        .pdf_flag  (pdf_flag),
        .chip_req  (chip_rst_req),
        .warm_req  (warm_rst_req)
    );

    assign cfg_rdata = cfg_q;

endmodule

// File: rtl/wdog_top_chk.sv
module wdog_top_chk (
    input logic       clk,
    input logic       rst,
    input logic       ext_rst,
    input logic       wdt_en_opt,
    input logic       halt_exec,
    input logic       in_halt,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       chip_rst_req,
    input logic       warm_rst_req,
    input logic       to_flag,
    input logic       pdf_flag
);

    a_r4_chip_pulse: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |=> !chip_rst_req);

    a_r4_warm_pulse: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |=> !warm_rst_req);

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(chip_rst_req && warm_rst_req));

    a_r4_chip_running: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |-> !$past(in_halt));

    a_r4_warm_halted: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |-> $past(in_halt));

    a_r8_req_sets_to: assert property (@(posedge clk) disable iff (rst)
        (chip_rst_req || warm_rst_req) |-> to_flag);

    a_r7_halt_flags: assert property (@(posedge clk) disable iff (rst)
        (halt_exec && !ext_rst) |=> (pdf_flag && !to_flag));

    a_r9_ext_reload: assert property (@(posedge clk) disable iff (rst)
        ext_rst |=> (cfg_rdata == 8'h07));

    a_r9_flags_kept: assert property (@(posedge clk) disable iff (rst)
        ext_rst |=> ($stable(to_flag) && $stable(pdf_flag)));

    a_r10_write_back: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !ext_rst) |=> (cfg_rdata == $past(cfg_wdata)));

    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (!wdt_en_opt && $past(!wdt_en_opt)) |-> (!chip_rst_req && !warm_rst_req));

endmodule

bind wdog_top wdog_top_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_rst      (ext_rst),
    .wdt_en_opt   (wdt_en_opt),
    .halt_exec    (halt_exec),
    .in_halt      (in_halt),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .chip_rst_req (chip_rst_req),
    .warm_rst_req (warm_rst_req),
    .to_flag      (to_flag),
    .pdf_flag     (pdf_flag)
);

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst = 0, wdt_en_opt = 1, dual_clr_opt = 0;
    logic [1:0] clk_src_sel = 2'd0;
    logic       tick_osc = 1, tick_rtc = 0, tick_instr = 1;
    logic       halt_exec = 0, in_halt = 0;
    logic       clr_one = 0, clr_a = 0, clr_b = 0;
    logic       cfg_we = 0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       chip_rst_req, warm_rst_req, to_flag, pdf_flag;

    always #10 clk = ~clk;  // 50 MHz

    wdog_top dut (.*);

    int compared = 0, mismatched = 0;
    bit armed = 0, done_flag = 0;
    int n_chip = 0, n_warm = 0;
    int rtc_div = 0;

    // reference model state
    int       m_cnt;
    bit       m_a, m_b, m_to, m_pdf, m_chip, m_warm;
    bit [7:0] m_cfg;

    task automatic cmp(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on each rising edge from pre-edge inputs
    always @(posedge clk) begin
        bit tk, na, nb, fin;
        int per;
        m_chip = 0; m_warm = 0;
        if (rst) begin
            m_cnt = 0; m_a = 0; m_b = 0; m_to = 0; m_pdf = 0; m_cfg = 8'h07;
        end else if (ext_rst) begin
            m_cnt = 0; m_a = 0; m_b = 0; m_cfg = 8'h07;
        end else begin
            per = 256 << m_cfg[2:0];
            case (clk_src_sel)
                2'd0: tk = tick_osc;
                2'd1: tk = tick_rtc;
                default: tk = tick_instr && !in_halt;
            endcase
            if (!wdt_en_opt) begin
                m_cnt = 0; m_a = 0; m_b = 0;
                if (halt_exec) begin m_pdf = 1; m_to = 0; end
            end else begin
                if (dual_clr_opt) begin
                    na = m_a | clr_a; nb = m_b | clr_b; fin = na && nb;
                end else begin
                    na = 0; nb = 0; fin = clr_one;
                end
                if (halt_exec) begin
                    m_cnt = 0; m_a = 0; m_b = 0; m_pdf = 1; m_to = 0;
                end else if (fin) begin
                    m_cnt = 0; m_a = 0; m_b = 0; m_pdf = 0; m_to = 0;
                end else begin
                    m_a = na; m_b = nb;
                    if (tk) begin
                        if ((m_cnt % per) == per - 1) begin
                            m_cnt = 0; m_a = 0; m_b = 0; m_to = 1;
                            if (in_halt) m_warm = 1; else m_chip = 1;
                        end else begin
                            m_cnt++;
                        end
                    end
                end
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
        if (!rst) armed <= 1;
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (armed && !done_flag) begin
            cmp("R4 chip_rst_req", chip_rst_req, m_chip);
            cmp("R4 warm_rst_req", warm_rst_req, m_warm);
            cmp("R8 to_flag", to_flag, m_to);
            cmp("R8 pdf_flag", pdf_flag, m_pdf);
            cmp("R10 cfg_rdata", cfg_rdata, m_cfg);
            n_chip += chip_rst_req;
            n_warm += warm_rst_req;
        end
    end

    // sparse real-time tick: one in three cycles
    always @(negedge clk) begin
        rtc_div = (rtc_div == 2) ? 0 : rtc_div + 1;
        tick_rtc = (rtc_div == 0);
    end

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic p_clr_one(); clr_one = 1; @(negedge clk); clr_one = 0; endtask
    task automatic p_clr_a();   clr_a = 1;   @(negedge clk); clr_a = 0;   endtask
    task automatic p_clr_b();   clr_b = 1;   @(negedge clk); clr_b = 0;   endtask
    task automatic p_halt();    halt_exec = 1; @(negedge clk); halt_exec = 0; endtask
    task automatic p_ext();     ext_rst = 1; @(negedge clk); ext_rst = 0; endtask
    task automatic wr(logic [7:0] v);
        cfg_we = 1; cfg_wdata = v; @(negedge clk); cfg_we = 0;
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        waitn(3);
        rst = 0;
        waitn(1);
        // R1 reset state
        cmp("R1 to_flag", to_flag, 0);
        cmp("R1 pdf_flag", pdf_flag, 0);
        cmp("R1 cfg_rdata", cfg_rdata, 8'h07);
        cmp("R1 chip_rst_req", chip_rst_req, 0);

        // R2/R10: minimum prescale, user bits set
        wr(8'hA8);
        cmp("R10 readback", cfg_rdata, 8'hA8);
        p_clr_one(); n_chip = 0;
        waitn(250);
        cmp("R2 no early timeout", n_chip, 0);
        waitn(20);
        cmp("R2 timeout after 256 ticks", n_chip, 1);
        cmp("R8 timeout sets flag", to_flag, 1);

        // R5 single-clear keeps the dog quiet
        p_clr_one(); n_chip = 0;
        cmp("R8 clear drops flag", to_flag, 0);
        for (int i = 0; i < 6; i++) begin waitn(200); p_clr_one(); end
        cmp("R5 periodic clear", n_chip, 0);
        p_clr_one(); n_chip = 0;
        for (int i = 0; i < 3; i++) begin waitn(80); p_clr_a(); p_clr_b(); end
        waitn(40);
        cmp("R5 paired strobes ignored", n_chip, 1);

        // R2 prescale 1:8
        wr(8'h03); p_clr_one(); n_chip = 0;
        waitn(2000);
        cmp("R2 ps3 early", n_chip, 0);
        waitn(100);
        cmp("R2 ps3 timeout", n_chip, 1);

        // R6 paired mode
        wr(8'h00); dual_clr_opt = 1;
        clr_a = 1; clr_b = 1; @(negedge clk); clr_a = 0; clr_b = 0;
        n_chip = 0;
        for (int i = 0; i < 4; i++) begin waitn(100); p_clr_a(); end
        cmp("R6 lone first strobe", (n_chip > 0) ? 1 : 0, 1);
        p_clr_a(); p_clr_b(); n_chip = 0;
        for (int i = 0; i < 5; i++) begin waitn(100); p_clr_b(); waitn(50); p_clr_a(); end
        cmp("R6 pair in either order", n_chip, 0);
        n_chip = 0;
        for (int i = 0; i < 4; i++) begin waitn(100); p_clr_one(); end
        cmp("R6 single strobe ignored", (n_chip > 0) ? 1 : 0, 1);
        // partial clear lost on timeout
        p_clr_a(); p_clr_b(); p_clr_a(); n_chip = 0;
        waitn(300);
        cmp("R6 expiry before second strobe", n_chip, 1);
        p_clr_b(); n_chip = 0;
        waitn(230);
        cmp("R6 stale first strobe forgotten", n_chip, 1);
        dual_clr_opt = 0;

        // R7/R4 halt with oscillator source: warm request
        p_clr_one();
        in_halt = 1; p_halt();
        cmp("R7 halt sets pdf", pdf_flag, 1);
        cmp("R7 halt clears to", to_flag, 0);
        n_chip = 0; n_warm = 0;
        waitn(300);
        cmp("R4 warm request in halt", n_warm, 1);
        cmp("R4 no chip request in halt", n_chip, 0);
        cmp("R8 pdf kept on timeout", pdf_flag, 1);

        // R3 instruction tick frozen in halt
        clk_src_sel = 2'd2; p_halt(); n_warm = 0;
        waitn(600);
        cmp("R3 instr tick frozen", n_warm, 0);
        in_halt = 0; n_chip = 0;
        waitn(300);
        cmp("R3 instr tick resumes", n_chip, 1);

        // R3 real-time tick source
        clk_src_sel = 2'd1; p_clr_one(); n_chip = 0;
        waitn(700);
        cmp("R3 rtc early", n_chip, 0);
        waitn(120);
        cmp("R3 rtc timeout", n_chip, 1);

        // R12 clear on the expiring tick wins
        clk_src_sel = 2'd0;
        p_clr_one(); n_chip = 0;
        waitn(255);
        p_clr_one();
        waitn(3);
        cmp("R12 clear beats expiry", n_chip, 0);

        // R11 disabled
        waitn(300);
        cmp("R11 setup to set", to_flag, 1);
        wdt_en_opt = 0; n_chip = 0;
        waitn(1000);
        cmp("R11 no request", n_chip, 0);
        p_clr_one();
        cmp("R11 clear has no effect", to_flag, 1);
        p_halt();
        cmp("R11 halt still sets pdf", pdf_flag, 1);
        cmp("R11 halt still clears to", to_flag, 0);
        wdt_en_opt = 1;

        // R9 external reset, then full 1:128 window
        wr(8'h40); waitn(300);
        cmp("R9 setup to", to_flag, 1);
        p_ext();
        cmp("R9 reload", cfg_rdata, 8'h07);
        cmp("R9 to kept", to_flag, 1);
        cmp("R9 pdf kept", pdf_flag, 1);
        n_chip = 0;
        waitn(32700);
        cmp("R2 max prescale early", n_chip, 0);
        waitn(100);
        cmp("R2 max prescale timeout", n_chip, 1);

        finish_run();
    end

endmodule